// File: doc/BRIEF.md
# Serial Peripheral Port Pin Controller

This block sits between a small serial shift engine and four shared package pins: slave select, serial clock, controller-out data and controller-in data. For each pin it decides the value driven and whether the driver is on. If the module is switched off, all four pins become plain general-purpose I/O, driven from the GPIO data and direction inputs. If it is switched on, the pins take their serial roles as master or slave. A single-wire mode makes one data pin carry traffic in both directions, and the port direction bit of that pin sets its direction.

A master transfer sends and receives an 8-bit frame, most significant bit first. The serial clock runs at half the bus clock, idles low, data changes on the falling edge and is sampled on the rising edge. A configuration input can make the CPU's wait state freeze a master transfer where it stands. The transfer then continues from the same bit when the wait ends. Pad inputs are assumed to be already synchronous to the bus clock.

Top module: `spi_pin_ctrl`

## Requirements
- R1: When `mod_en` is 0, `pin_out` equals `gpio_dout` and `pin_oe` equals `pin_dir` on all four pins. The pin indices are 0 = select, 1 = clock, 2 = controller-out data, 3 = controller-in data.
- R2: In master mode (`mod_en`=1, `is_master`=1, `bidir`=0), pins 1 and 2 are driven (`pin_oe`=1) and pin 3 is not driven. In every enabled mode, an undriven pin has `pin_out` 0.
- R3: In slave mode (`mod_en`=1, `is_master`=0), pins 0, 1 and 2 are never driven. With `bidir`=0, pin 3 is driven exactly while `pin_in[0]` is 0.
- R4: In single-wire master mode (`bidir`=1), `pin_oe[2]` follows `pin_dir[2]`, pin 3 is not driven, and received bits are taken from `pin_in[2]`.
- R5: In single-wire slave mode, `pin_oe[3]` is `pin_dir[3]` while `pin_in[0]` is 0 and is 0 otherwise. Received bits are taken from `pin_in[3]`.
- R6: In master mode, pin 0 is driven only when `pin_dir[0]` is 1. It then carries the frame select (low during a transfer) if `ss_auto` is 1, and `gpio_dout[0]` if `ss_auto` is 0.
- R7: While `rst_n` is low, every `pin_out` and `pin_oe` bit is 0. After reset, `rx_byte` is 0 and `busy` is 0.
- R8: In master mode, a `tx_start` seen while idle has the following effects:
  - In the next cycle, `busy` is 1, the frame select is low, the clock is low and pin 2 shows bit 7 of `tx_byte`.
  - The clock then toggles on every bus clock for 8 rising edges. Data changes only on falling edges. Bit i of the received byte (7 down to 0) is the input sampled at rising edge 8-i.
  - After the 16th toggle, `busy` falls, the select returns high, `rx_valid` pulses for one cycle and `rx_byte` holds the received byte.
  - A `tx_start` during a transfer is ignored.
- R9: With `wait_halt`=1, every cycle in which `cpu_wait` is 1 during a master transfer holds the clock level, the bit position and the shift contents. The transfer lasts exactly that many cycles longer than 16 and produces no extra clock edges.
- R10: With `wait_halt`=0, `cpu_wait` has no effect, and a master transfer lasts 16 cycles.
- R11: In slave mode, while `pin_in[0]` is 1, edges on `pin_in[1]` are ignored. They produce no `rx_valid`, and the next selected frame starts again from bit 7 of `tx_byte`.
- R12: In slave mode with the select low, each rising clock edge samples the data input and each falling edge advances the output to the next lower bit of `tx_byte`. After the 8th falling edge, `rx_valid` pulses and `rx_byte` holds the received byte, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_en | input | 1 | Serial function enable; 0 gives GPIO fallback |
| is_master | input | 1 | 1 = master, 0 = slave |
| bidir | input | 1 | Single-wire data mode |
| ss_auto | input | 1 | Master drives frame select on pin 0 |
| wait_halt | input | 1 | CPU wait freezes master transfers |
| cpu_wait | input | 1 | CPU is in wait state |
| pin_dir | input | 4 | Per-pin direction bits (1 = output) |
| gpio_dout | input | 4 | GPIO output data |
| pin_in | input | 4 | Pad input values |
| tx_byte | input | 8 | Frame to send |
| tx_start | input | 1 | Start a master frame |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables |
| rx_byte | output | 8 | Last received frame |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| busy | output | 1 | Master transfer in progress |

## Verification
The master path runs against pseudo-random input data that changes every bus clock, so a wrong sampling edge or an off-by-one bit order shows up in `rx_byte`. It runs in both the separate-wire and single-wire modes, with each direction bit, so that a wrong input pin is exposed. Wait pulses are applied once with freezing enabled and once with it disabled, and the busy length is compared against 20 and 16 cycles respectively. The slave path receives known bytes and has its outgoing bits captured. Clock toggling with the select high comes before a frame, to show that no state leaks across a deselected period. GPIO fallback and reset use nonzero direction and data patterns, so that a pin forced to zero can be told apart from a passed-through one.

// File: rtl/spi_pin_pkg.sv
// Shared pin indices and mode encoding for the serial port pin controller.
package spi_pin_pkg;
    localparam int PIN_COUNT = 4;
    localparam int PIN_SS    = 0;
    localparam int PIN_SCK   = 1;
    localparam int PIN_MOSI  = 2;
    localparam int PIN_MISO  = 3;

    typedef enum logic [1:0] {
        LINK_OFF    = 2'd0,
        LINK_MASTER = 2'd1,
        LINK_SLAVE  = 2'd2
    } link_mode_e;
endpackage

// File: rtl/spi_tick_gen.sv
// Serial clock phase tick generator.
// Emits one tick every HALF_PER cycles in which run is high; cycles with
// run low leave the count untouched, so a pause resumes mid-phase.
// Assumes clear is asserted whenever no transfer is in progress.
module spi_tick_gen #(
    parameter int HALF_PER = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);

    logic [CW-1:0] cnt;

    // Phase counter: wraps at LAST, held when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spi_master_eng.sv
// Master shift engine: one frame per start, MSB first, clock idle low,
// data changes on the falling edge and is sampled on the rising edge.
// A hold input freezes the frame in place (clock level, bit position,
// shift contents). Assumes din is synchronous to clk.
module spi_master_eng #(
    parameter int FRAME_BITS = 8,
    parameter int HALF_PER   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  din,
    input  logic                  hold,
    output logic                  sck,
    output logic                  mosi,
    output logic                  ss_n,
    output logic                  busy,
    output logic                  frame_end,
    output logic [FRAME_BITS-1:0] frame_word
);
    localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic                  active;
    logic                  sck_q;
    logic                  rx_bit;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  tick;

    spi_tick_gen #(.HALF_PER(HALF_PER)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active && !hold),
        .clear (!active),
        .tick  (tick)
    );

    // Frame sequencing: start, rising-edge sample, falling-edge shift, end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sck_q   <= 1'b0;
            rx_bit  <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (!enable) begin
            active  <= 1'b0;
            sck_q   <= 1'b0;
            bit_cnt <= '0;
        end else if (!active) begin
            if (start) begin
                active  <= 1'b1;
                sck_q   <= 1'b0;
                shreg   <= tx_word;
                bit_cnt <= '0;
            end
        end else if (tick) begin
            if (!sck_q) begin
                sck_q  <= 1'b1;
                rx_bit <= din;
            end else begin
                sck_q <= 1'b0;
                shreg <= {shreg[FRAME_BITS-2:0], rx_bit};
                if (bit_cnt == LAST_BIT) begin
                    active  <= 1'b0;
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign frame_end  = enable && active && tick && sck_q && (bit_cnt == LAST_BIT);
    assign frame_word = {shreg[FRAME_BITS-2:0], rx_bit};
    assign sck        = sck_q;
    assign mosi       = active && shreg[FRAME_BITS-1];
    assign ss_n       = !active;
    assign busy       = active;

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hold && enable) |=>
            (active && sck_q == $past(sck_q) && bit_cnt == $past(bit_cnt)
             && shreg == $past(shreg)));

    // R8
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> !ss_n);

    // R8
    frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (ss_n && !sck_q));
endmodule

// File: rtl/spi_slave_eng.sv
// Slave shift engine: follows an external clock while selected.
// Rising edge samples din, falling edge shifts; while deselected the
// outgoing word is reloaded and the bit position cleared.
// Assumes sck_in and ss_in are synchronous to clk.
module spi_slave_eng #(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  ss_in,
    input  logic                  sck_in,
    input  logic                  din,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  dout,
    output logic                  frame_end,
    output logic [FRAME_BITS-1:0] frame_word
);
    localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic                  sck_prev;
    logic                  rx_bit;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  rise;
    logic                  fall;
    logic                  selected;

    assign selected = enable && !ss_in;
    assign rise     = selected && sck_in && !sck_prev;
    assign fall     = selected && !sck_in && sck_prev;

    // Clock edge history, tracked regardless of selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_in;
        end
    end

    // Shift state: reload when deselected, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_bit  <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (!selected) begin
            shreg   <= tx_word;
            bit_cnt <= '0;
        end else if (rise) begin
            rx_bit <= din;
        end else if (fall) begin
            shreg   <= {shreg[FRAME_BITS-2:0], rx_bit};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    assign frame_end  = fall && (bit_cnt == LAST_BIT);
    assign frame_word = {shreg[FRAME_BITS-2:0], rx_bit};
    assign dout       = shreg[FRAME_BITS-1];

    // R11
    deselect_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ss_in) |=> (bit_cnt == '0 && shreg == $past(tx_word)));
endmodule

// File: rtl/spi_pin_mux.sv
// Pin direction and value multiplexer for the four shared pins.
// Chooses GPIO fallback, master or slave roles; applies single-wire
// turnaround from the port direction bits; forces all pins to zero
// while live is low (reset).
module spi_pin_mux
    import spi_pin_pkg::*;
(
    input  logic                 live,
    input  logic                 mod_en,
    input  logic                 is_master,
    input  logic                 bidir,
    input  logic                 ss_auto,
    input  logic [PIN_COUNT-1:0] pin_dir,
    input  logic [PIN_COUNT-1:0] gpio_dout,
    input  logic                 ss_in,
    input  logic                 mosi_in,
    input  logic                 miso_in,
    input  logic                 m_sck,
    input  logic                 m_mosi,
    input  logic                 m_ss_n,
    input  logic                 s_dout,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 m_din,
    output logic                 s_din
);
    link_mode_e mode;

    // Mode decode from enable and role.
    always_comb begin
        if (!mod_en) begin
            mode = LINK_OFF;
        end else if (is_master) begin
            mode = LINK_MASTER;
        end else begin
            mode = LINK_SLAVE;
        end
    end

    // Per-pin output value and enable.
    always_comb begin
        pin_out = '0;
        pin_oe  = '0;
        unique case (mode)
            LINK_OFF: begin
                pin_out = gpio_dout;
                pin_oe  = pin_dir;
            end
            LINK_MASTER: begin
                pin_oe[PIN_SCK]   = 1'b1;
                pin_out[PIN_SCK]  = m_sck;
                pin_oe[PIN_MOSI]  = bidir ? pin_dir[PIN_MOSI] : 1'b1;
                pin_out[PIN_MOSI] = pin_oe[PIN_MOSI] && m_mosi;
                if (pin_dir[PIN_SS]) begin
                    pin_oe[PIN_SS]  = 1'b1;
                    pin_out[PIN_SS] = ss_auto ? m_ss_n : gpio_dout[PIN_SS];
                end
            end
            LINK_SLAVE: begin
                pin_oe[PIN_MISO]  = !ss_in && (!bidir || pin_dir[PIN_MISO]);
                pin_out[PIN_MISO] = pin_oe[PIN_MISO] && s_dout;
            end
            default: begin
                pin_out = '0;
                pin_oe  = '0;
            end
        endcase
        if (!live) begin
            pin_out = '0;
            pin_oe  = '0;
        end
    end

    // Receive data source for each role.
    assign m_din = bidir ? mosi_in : miso_in;
    assign s_din = bidir ? miso_in : mosi_in;
endmodule

// File: rtl/spi_pin_ctrl.sv
// Serial port pin controller top: GPIO fallback, master/slave pin roles,
// single-wire data mode and wait-state freezing of master transfers.
// Assumes pad inputs are already synchronous to clk.
module spi_pin_ctrl
    import spi_pin_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int SCK_HALF   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mod_en,
    input  logic                  is_master,
    input  logic                  bidir,
    input  logic                  ss_auto,
    input  logic                  wait_halt,
    input  logic                  cpu_wait,
    input  logic [PIN_COUNT-1:0]  pin_dir,
    input  logic [PIN_COUNT-1:0]  gpio_dout,
    input  logic [PIN_COUNT-1:0]  pin_in,
    input  logic [FRAME_BITS-1:0] tx_byte,
    input  logic                  tx_start,
    output logic [PIN_COUNT-1:0]  pin_out,
    output logic [PIN_COUNT-1:0]  pin_oe,
    output logic [FRAME_BITS-1:0] rx_byte,
    output logic                  rx_valid,
    output logic                  busy
);
    logic                  m_en, s_en;
    logic                  m_sck, m_mosi, m_ss_n, m_end;
    logic                  s_dout, s_end;
    logic                  m_din, s_din;
    logic [FRAME_BITS-1:0] m_word, s_word;
    logic [FRAME_BITS-1:0] rx_q;
    logic                  valid_q;

    assign m_en = mod_en && is_master;
    assign s_en = mod_en && !is_master;

    spi_master_eng #(.FRAME_BITS(FRAME_BITS), .HALF_PER(SCK_HALF)) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (m_en),
        .start      (tx_start),
        .tx_word    (tx_byte),
        .din        (m_din),
        .hold       (wait_halt && cpu_wait),
        .sck        (m_sck),
        .mosi       (m_mosi),
        .ss_n       (m_ss_n),
        .busy       (busy),
        .frame_end  (m_end),
        .frame_word (m_word)
    );

    spi_slave_eng #(.FRAME_BITS(FRAME_BITS)) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (s_en),
        .ss_in      (pin_in[PIN_SS]),
        .sck_in     (pin_in[PIN_SCK]),
        .din        (s_din),
        .tx_word    (tx_byte),
        .dout       (s_dout),
        .frame_end  (s_end),
        .frame_word (s_word)
    );

    spi_pin_mux u_mux (
        .live      (rst_n),
        .mod_en    (mod_en),
        .is_master (is_master),
        .bidir     (bidir),
        .ss_auto   (ss_auto),
        .pin_dir   (pin_dir),
        .gpio_dout (gpio_dout),
        .ss_in     (pin_in[PIN_SS]),
        .mosi_in   (pin_in[PIN_MOSI]),
        .miso_in   (pin_in[PIN_MISO]),
        .m_sck     (m_sck),
        .m_mosi    (m_mosi),
        .m_ss_n    (m_ss_n),
        .s_dout    (s_dout),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .m_din     (m_din),
        .s_din     (s_din)
    );

    // Received word capture from whichever engine finished a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= m_end || s_end;
            if (m_end) begin
                rx_q <= m_word;
            end else if (s_end) begin
                rx_q <= s_word;
            end
        end
    end

    assign rx_byte  = rx_q;
    assign rx_valid = valid_q;

    // R3
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_en && pin_in[PIN_SS]) |-> (pin_oe == '0));

    // R2
    master_in_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_en |-> (!pin_oe[PIN_MISO] && pin_oe[PIN_SCK]));
endmodule

// File: tb/spi_pin_ctrl_bench.sv
module spi_pin_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_en = 1'b0, is_master = 1'b0, bidir = 1'b0, ss_auto = 1'b0;
    logic       wait_halt = 1'b0, cpu_wait = 1'b0;
    logic [3:0] pin_dir = 4'hF, gpio_dout = 4'hA, drv_in = 4'h1;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_start = 1'b0;
    logic       noise_on = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    logic [3:0] pin_in;
    logic [3:0] pin_out, pin_oe;
    logic [7:0] rx_byte;
    logic       rx_valid, busy;

    int checks = 0, fails = 0, cycles = 0, busy_cnt = 0, valid_cnt = 0;
    string cur_req = "R7";
    bit   finished = 0;

    // model state
    bit       m_on = 0;
    int       m_t = 0;
    logic [7:0] m_tx = 0, m_rx = 0;
    int       s_k = 0;
    logic [7:0] s_tx = 0, s_rx = 0;
    logic     s_prev = 0;
    logic [7:0] exp_rx = 0;
    bit       ev = 0;

    assign pin_in = {noise_on ? lfsr[1] : drv_in[3], noise_on ? lfsr[0] : drv_in[2], drv_in[1:0]};

    spi_pin_ctrl u_spi_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .is_master(is_master),
        .bidir(bidir), .ss_auto(ss_auto), .wait_halt(wait_halt), .cpu_wait(cpu_wait),
        .pin_dir(pin_dir), .gpio_dout(gpio_dout), .pin_in(pin_in),
        .tx_byte(tx_byte), .tx_start(tx_start), .pin_out(pin_out), .pin_oe(pin_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .busy(busy));

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // input noise source
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    // behavioural reference, advanced on each rising clock
    always @(posedge clk) begin
        ev = 0;
        if (!rst_n) begin
            m_on = 0; m_t = 0; s_k = 0; s_prev = 0; exp_rx = 0;
        end else begin
            if (!(mod_en && is_master)) m_on = 0;
            else if (m_on) begin
                if (!(wait_halt && cpu_wait)) begin
                    if (m_t % 2 == 0) m_rx[7 - m_t / 2] = bidir ? pin_in[2] : pin_in[3];
                    m_t++;
                    if (m_t == 16) begin m_on = 0; exp_rx = m_rx; ev = 1; end
                end
            end else if (tx_start) begin
                m_on = 1; m_t = 0; m_tx = tx_byte; m_rx = 0;
            end
            if (!(mod_en && !is_master) || pin_in[0]) begin
                s_k = 0; s_tx = tx_byte;
            end else if (pin_in[1] && !s_prev) begin
                s_rx[7 - s_k] = bidir ? pin_in[3] : pin_in[2];
            end else if (!pin_in[1] && s_prev) begin
                s_k++;
                if (s_k == 8) begin s_k = 0; s_tx = s_rx; exp_rx = s_rx; ev = 1; end
            end
            s_prev = pin_in[1];
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [3:0] eo, eoe;
        logic sck_e, mosi_e;
        if (!finished) begin
            eo = 0; eoe = 0;
            sck_e = m_on && (m_t % 2 == 1);
            mosi_e = m_on ? m_tx[7 - m_t / 2] : 1'b0;
            if (!rst_n) begin eo = 0; eoe = 0; end
            else if (!mod_en) begin eo = gpio_dout; eoe = pin_dir; end
            else if (is_master) begin
                eoe[1] = 1; eo[1] = sck_e;
                eoe[2] = bidir ? pin_dir[2] : 1'b1; eo[2] = eoe[2] & mosi_e;
                if (pin_dir[0]) begin eoe[0] = 1; eo[0] = ss_auto ? !m_on : gpio_dout[0]; end
            end else begin
                eoe[3] = !pin_in[0] && (!bidir || pin_dir[3]);
                eo[3] = eoe[3] & s_tx[7 - s_k];
            end
            chk(cur_req, {pin_out, pin_oe}, {eo, eoe});
            chk(cur_req, busy, m_on);
            chk(cur_req, rx_valid, ev);
            chk(cur_req, rx_byte, exp_rx);
            if (busy) busy_cnt++;
            if (rx_valid) valid_cnt++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic master_frame(input logic [7:0] b, input int pause_at, input int pause_len);
        tx_byte = b; tx_start = 1; busy_cnt = 0;
        tick(1);
        tx_start = 0;
        if (pause_len > 0) begin
            tick(pause_at); cpu_wait = 1; tick(pause_len); cpu_wait = 0;
            tick(24 - pause_at - pause_len);
        end else begin
            tick(3); tx_start = 1; tx_byte = ~b; tick(1); tx_start = 0;
            tick(20);
        end
    endtask

    task automatic slave_frame(input logic [7:0] din, output logic [7:0] seen);
        int idx;
        idx = bidir ? 3 : 2;
        drv_in[0] = 0; tick(2);
        for (int i = 7; i >= 0; i--) begin
            drv_in[idx] = din[i]; tick(1);
            drv_in[1] = 1; tick(1);
            seen[i] = pin_out[3];
            drv_in[1] = 0; tick(1);
        end
        tick(1); drv_in[0] = 1; tick(2);
    endtask

    initial begin
        logic [7:0] seen;
        // reset with active GPIO pattern
        cur_req = "R7";
        tick(3);
        chk("R7", {pin_out, pin_oe}, 8'h00);
        rst_n = 1;
        tick(1);
        chk("R7", rx_byte, 8'h00);
        chk("R7", busy, 1'b0);

        cur_req = "R1";
        gpio_dout = 4'h5; pin_dir = 4'h6; tick(2);
        chk("R1", {pin_out, pin_oe}, {4'h5, 4'h6});
        gpio_dout = 4'hC; pin_dir = 4'h9; tick(2);

        cur_req = "R8";
        mod_en = 1; is_master = 1; ss_auto = 1; pin_dir = 4'b0001; noise_on = 1;
        tick(1);
        chk("R2", pin_oe, 4'b0111);
        master_frame(8'hA5, 0, 0);
        chk("R8", busy_cnt, 16);
        master_frame(8'h3C, 0, 0);

        cur_req = "R6";
        ss_auto = 0; gpio_dout = 4'h1; tick(3);
        chk("R6", pin_out[0], 1'b1);
        gpio_dout = 4'h0; master_frame(8'h81, 0, 0);
        pin_dir = 4'b0000; tick(3);
        chk("R6", pin_oe[0], 1'b0);
        pin_dir = 4'b0001; ss_auto = 1;

        cur_req = "R9";
        wait_halt = 1;
        master_frame(8'h6E, 5, 4);
        chk("R9", busy_cnt, 20);

        cur_req = "R10";
        wait_halt = 0;
        master_frame(8'h17, 6, 4);
        chk("R10", busy_cnt, 16);

        cur_req = "R4";
        bidir = 1; pin_dir = 4'b0101;
        master_frame(8'hD2, 0, 0);
        pin_dir = 4'b0001;
        master_frame(8'h4B, 0, 0);
        chk("R4", pin_oe[3:2], 2'b00);

        cur_req = "R12";
        noise_on = 0; bidir = 0; is_master = 0; drv_in = 4'b0001; tx_byte = 8'h3C;
        tick(2);
        slave_frame(8'h96, seen);
        chk("R12", rx_byte, 8'h96);
        chk("R12", seen, 8'h3C);
        chk("R3", pin_oe, 4'b0000);

        cur_req = "R11";
        valid_cnt = 0; tx_byte = 8'hE1;
        for (int i = 0; i < 6; i++) begin
            drv_in[1] = ~drv_in[1]; drv_in[2] = i[0]; tick(1);
            chk("R11", pin_oe[3], 1'b0);
        end
        drv_in[1] = 0; tick(2);
        chk("R11", valid_cnt, 0);
        slave_frame(8'h5A, seen);
        chk("R11", seen, 8'hE1);
        chk("R11", rx_byte, 8'h5A);

        cur_req = "R5";
        bidir = 1; pin_dir = 4'b1000; tx_byte = 8'hB4; tick(2);
        slave_frame(8'h2D, seen);
        chk("R5", rx_byte, 8'h2D);
        chk("R5", seen, 8'hB4);
        pin_dir = 4'b0000; drv_in[0] = 0; tick(2);
        chk("R5", pin_oe[3], 1'b0);
        drv_in[0] = 1; tick(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule